// File: doc/BRIEF.md
# Crypto Coprocessor Command Executor

This block is a small cryptographic coprocessor. It runs 9-bit commands against a register file of eleven 32-bit entries: a status word, an accumulator and nine general registers. Each command has a 5-bit operation field in bits 8:4 and a 4-bit register selector in bits 3:0. The selector values are 0 for status, 1 for the accumulator, and 2 to 10 for general registers 0 to 8. Selectors 11 to 15 are unimplemented.

Software issues work in one of two ways. A single write (`cmd_packed`=0) carries one command in `cmd_word[8:0]`, with a 32-bit operand on `operand`. It executes at the clock edge that accepts it. A packed write (`cmd_packed`=1) carries up to three operand-free commands. Each command sits under a marker bit: slot A uses marker 31 and command bits 30:22, slot B uses marker 20 and bits 19:11, and slot C uses marker 9 and bits 8:0. The slots execute one per clock in the order A, B, C, and `busy` holds off further writes until they finish.

The datapath covers wrapping addition, addition of a byte-reversed operand, XOR, rotation, accumulator moves, AES forward and inverse byte substitution on all four bytes, and a MixColumns step with an XOR. The S-boxes are computed from field arithmetic rather than stored. Store commands return a word on a registered read port. Bad commands raise a sticky flag in bit 0 of the status word.

Top module: `crypto_cmd_engine`

## Requirements
- R1: After reset, every register reads zero, and `busy`, `rd_valid` and `err` are low.
- R2: A write is accepted when `cmd_valid` is high and `busy` is low. Operation 0x01 loads the operand into the selected register. Operation 0x02 presents the register on `rd_data`, with `rd_valid` high for the one cycle after acceptance.
- R3: Operation 0x03 adds the operand to the register, modulo 2^32. Operation 0x04 adds the operand after swapping bytes 0↔3 and 1↔2.
- R4: Operation 0x06 XORs the operand into the register. Operation 0x07 rotates the register left by operand[4:0].
- R5: Operation 0x05 adds the register into the accumulator. Operation 0x08 copies the register to the accumulator. Operation 0x09 copies the accumulator to the register.
- R6: Operation 0x0A replaces each byte of the register with its AES S-box value. Operation 0x0B applies the inverse S-box.
- R7: Operation 0x0C applies MixColumns to the register, taking byte 3 as row 0, and then XORs in the operand.
- R8: A packed write with markers {31,20,9} of 100, 110 or 111 runs one, two or three slots in order A, B, C, one per clock. `busy` is high for that many cycles, and writes made while `busy` is high have no effect.
- R9: A packed write with any other marker pattern pulses `err` for one cycle and executes nothing.
- R10: The following set status bit 0 and change no register: the illegal opcode 0x1F0, a reserved operation (0x0D to 0x1E), operation 0 with a non-zero selector, a selector above 10, and an operand-using operation (0x01, 0x02, 0x03, 0x04, 0x06, 0x07, 0x0C) inside a packed write.
- R11: Status bit 0 stays set through later commands until a command writes the status register. Loading 0 into status clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Write request |
| cmd_packed | input | 1 | 1: packed word, 0: single command with operand |
| cmd_word | input | 32 | Command word |
| operand | input | 32 | Operand for a single command |
| busy | output | 1 | Packed slots still pending; writes are ignored |
| err | output | 1 | One-cycle pulse for a bad marker pattern |
| rd_valid | output | 1 | Store result valid |
| rd_data | output | 32 | Store result |

## Verification
The hardest case to reach from the ports is slot ordering inside a packed write, because every packed slot is operand-free and moves only existing register values. The bench first loads two distinct general registers with single writes. It then issues a packed write whose three slots form an accumulator chain (copy, add, copy back), and the final value is correct only if the slots run in A, B, C order. A write is also driven while `busy` is high, and a later read of its target register shows that the write was dropped.

// File: rtl/crypto_cmd_pkg.sv
package crypto_cmd_pkg;
    localparam int DW      = 32;
    localparam int CMDW    = 9;
    localparam int OPW     = 5;
    localparam int SELW    = 4;
    localparam int NGEN    = 9;
    localparam int NREG    = NGEN + 2;
    localparam int NSLOT   = 3;
    localparam int SEL_ST  = 0;
    localparam int SEL_ACC = 1;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 5'h00, OP_LDR  = 5'h01, OP_STR  = 5'h02, OP_ADR  = 5'h03,
        OP_RADR = 5'h04, OP_ADRA = 5'h05, OP_XOR  = 5'h06, OP_ROTL = 5'h07,
        OP_MVRA = 5'h08, OP_MVAR = 5'h09, OP_AESS = 5'h0A, OP_AESI = 5'h0B,
        OP_AESC = 5'h0C, OP_ILL  = 5'h1F
    } op_e;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    rd_vld;
        logic [DW-1:0]           rd_data;
    } eng_t;

    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p, t;
        p = '0;
        t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ t;
            t = gf_x2(t);
        end
        return p;
    endfunction

    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p, r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rl8(input logic [7:0] a, input int n);
        logic [15:0] t;
        t = {a, a} << n;
        return t[15:8];
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rl8(b, 1) ^ rl8(b, 2) ^ rl8(b, 3) ^ rl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sbox_inv(input logic [7:0] a);
        return gf_inv(rl8(a, 1) ^ rl8(a, 3) ^ rl8(a, 6) ^ 8'h05);
    endfunction
endpackage

// File: rtl/aes_sub_word.sv
module aes_sub_word
    import crypto_cmd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        if (INVERSE) begin : g_inv
            assign dout[8*i +: 8] = sbox_inv(din[8*i +: 8]);
        end else begin : g_fwd
            assign dout[8*i +: 8] = sbox_fwd(din[8*i +: 8]);
        end
    end
endmodule

// File: rtl/aes_mix_col.sv
module aes_mix_col
    import crypto_cmd_pkg::*;
(
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [7:0] r0, r1, r2, r3;

    always_comb begin
        r0 = din[31:24];
        r1 = din[23:16];
        r2 = din[15:8];
        r3 = din[7:0];
        dout[31:24] = gf_x2(r0) ^ gf_x2(r1) ^ r1 ^ r2 ^ r3;
        dout[23:16] = r0 ^ gf_x2(r1) ^ gf_x2(r2) ^ r2 ^ r3;
        dout[15:8]  = r0 ^ r1 ^ gf_x2(r2) ^ gf_x2(r3) ^ r3;
        dout[7:0]   = gf_x2(r0) ^ r0 ^ r1 ^ r2 ^ gf_x2(r3);
    end
endmodule

// File: rtl/crypto_cmd_seq.sv
module crypto_cmd_seq
    import crypto_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   word,
    output logic            busy,
    output logic            err,
    output logic [CMDW-1:0] head
);
    localparam int CW = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [NSLOT-1:0][CMDW-1:0] slots;
        logic [CW-1:0]              cnt;
        logic                       err;
    } seq_t;

    seq_t s_d, s_q;
    logic [2:0] marks;

    assign marks = {word[31], word[20], word[9]};

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (s_q.cnt != '0) begin
            s_d.slots = s_q.slots >> CMDW;
            s_d.cnt   = s_q.cnt - 1'b1;
        end else if (wr_en) begin
            s_d.slots = {word[8:0], word[19:11], word[30:22]};
            unique case (marks)
                3'b100:  s_d.cnt = CW'(1);
                3'b110:  s_d.cnt = CW'(2);
                3'b111:  s_d.cnt = CW'(3);
                default: s_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.cnt != '0);
    assign err  = s_q.err;
    assign head = s_q.slots[0];
endmodule

// File: rtl/crypto_cmd_engine.sv
module crypto_cmd_engine
    import crypto_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_packed,
    input  logic [31:0]   cmd_word,
    input  logic [31:0]   operand,
    output logic          busy,
    output logic          err,
    output logic          rd_valid,
    output logic [31:0]   rd_data
);
    eng_t q, d;

    logic            accept, single_go, exec_vld;
    logic [CMDW-1:0] head, cmd;
    logic [OPW-1:0]  op;
    logic [SELW-1:0] sel;
    logic [DW-1:0]   cur, sub_f, sub_i, mixed, brev, wval;
    logic [2*DW-1:0] rot2;
    logic            uses_opnd, bad, writes;
    logic            ill_flag;

    assign accept    = cmd_valid && !busy;
    assign single_go = accept && !cmd_packed;
    assign exec_vld  = busy || single_go;
    assign cmd       = busy ? head : cmd_word[CMDW-1:0];
    assign op        = cmd[CMDW-1 -: OPW];
    assign sel       = cmd[SELW-1:0];
    assign cur       = (int'(sel) < NREG) ? q.regs[sel] : '0;
    assign brev      = {operand[7:0], operand[15:8], operand[23:16], operand[31:24]};
    assign rot2      = {cur, cur} << operand[4:0];

    crypto_cmd_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept && cmd_packed),
        .word  (cmd_word),
        .busy  (busy),
        .err   (err),
        .head  (head)
    );

    aes_sub_word #(.INVERSE(1'b0)) u_sub_f (.din(cur), .dout(sub_f));
    aes_sub_word #(.INVERSE(1'b1)) u_sub_i (.din(cur), .dout(sub_i));
    aes_mix_col u_mix (.din(cur), .dout(mixed));

    always_comb begin
        uses_opnd = 1'b0;
        bad       = 1'b0;
        writes    = 1'b1;
        wval      = cur;
        unique case (op)
            OP_NOP:  begin writes = 1'b0; bad = (sel != '0); end
            OP_LDR:  begin uses_opnd = 1'b1; wval = operand; end
            OP_STR:  begin uses_opnd = 1'b1; writes = 1'b0; end
            OP_ADR:  begin uses_opnd = 1'b1; wval = cur + operand; end
            OP_RADR: begin uses_opnd = 1'b1; wval = cur + brev; end
            OP_ADRA: writes = 1'b0;
            OP_XOR:  begin uses_opnd = 1'b1; wval = cur ^ operand; end
            OP_ROTL: begin uses_opnd = 1'b1; wval = rot2[2*DW-1:DW]; end
            OP_MVRA: writes = 1'b0;
            OP_MVAR: wval = q.regs[SEL_ACC];
            OP_AESS: wval = sub_f;
            OP_AESI: wval = sub_i;
            OP_AESC: begin uses_opnd = 1'b1; wval = mixed ^ operand; end
            default: begin writes = 1'b0; bad = 1'b1; end
        endcase
        if (int'(sel) >= NREG) bad = 1'b1;
        if (busy && uses_opnd) bad = 1'b1;
    end

    always_comb begin
        d        = q;
        d.rd_vld = 1'b0;
        if (exec_vld) begin
            if (bad) begin
                d.regs[SEL_ST][0] = 1'b1;
            end else begin
                if (writes) d.regs[sel] = wval;
                if (op == OP_ADRA) d.regs[SEL_ACC] = q.regs[SEL_ACC] + cur;
                if (op == OP_MVRA) d.regs[SEL_ACC] = cur;
                if (op == OP_STR) begin
                    d.rd_vld  = 1'b1;
                    d.rd_data = cur;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = q.rd_vld;
    assign rd_data  = q.rd_data;
    assign ill_flag = q.regs[SEL_ST][0];
endmodule

// File: rtl/crypto_cmd_engine_chk.sv
module crypto_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_packed,
    input logic [8:0] cmd_lo,
    input logic [2:0] marks,
    input logic       busy,
    input logic       err,
    input logic       rd_valid,
    input logic       ill_flag
);
    // R2
    rd_after_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !cmd_packed && !busy));

    // R9
    err_after_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cmd_valid && cmd_packed && !busy));

    // R9
    err_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err, rd_valid}));

    // R8
    triple_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_packed && !busy && marks == 3'b111) |=> busy);

    // R8
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_packed)) |=> !busy);

    // R10
    ill_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_packed && !busy && cmd_lo == 9'h1F0) |=> ill_flag);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_flag && !busy && !(cmd_valid && !cmd_packed)) |=> ill_flag);
endmodule

bind crypto_cmd_engine crypto_cmd_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_packed (cmd_packed),
    .cmd_lo     (cmd_word[8:0]),
    .marks      ({cmd_word[31], cmd_word[20], cmd_word[9]}),
    .busy       (busy),
    .err        (err),
    .rd_valid   (rd_valid),
    .ill_flag   (ill_flag)
);

// File: tb/crypto_cmd_engine_tb.sv
module crypto_cmd_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_packed = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] operand = '0;
    logic        busy, err, rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crypto_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_packed(cmd_packed),
        .cmd_word(cmd_word), .operand(operand), .busy(busy), .err(err),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [8:0] mk(input logic [4:0] op, input logic [3:0] sel);
        return {op, sel};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [8:0] c, input logic [31:0] opnd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_packed = 1'b0;
        cmd_word = {23'b0, c}; operand = opnd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] sel, output logic [31:0] v);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_packed = 1'b0;
        cmd_word = {23'b0, mk(5'h02, sel)}; operand = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        v = rd_valid ? rd_data : 32'hxxxx_xxxx;
    endtask

    task automatic expect_reg(input logic [3:0] sel, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        read_reg(sel, v);
        check(v === exp, tag, v, exp);
    endtask

    task automatic issue_packed(input logic [31:0] w, output int busy_cycles, output logic saw_err);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_packed = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_packed = 1'b0;
        saw_err = err;
        busy_cycles = 0;
        while (busy && busy_cycles < 10) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] pack(input logic [2:0] m, input logic [8:0] a,
                                         input logic [8:0] b, input logic [8:0] c);
        return {m[2], a, 1'b0, m[1], b, 1'b0, m[0], c};
    endfunction

    task automatic t_reset();
        check(!busy && !err && !rd_valid, "R1 outputs", {29'b0, busy, err, rd_valid}, 0);
        for (int s = 0; s < 11; s++) expect_reg(4'(s), 0, "R1 reg zero");
    endtask

    task automatic t_load_store();
        issue(mk(5'h01, 4'd2), 32'hA5A5_0001);
        expect_reg(4'd2, 32'hA5A5_0001, "R2 load/store r2");
        issue(mk(5'h01, 4'd10), 32'h1234_5678);
        expect_reg(4'd10, 32'h1234_5678, "R2 load/store r10");
    endtask

    task automatic t_add();
        issue(mk(5'h01, 4'd3), 32'hFFFF_FFFF);
        issue(mk(5'h03, 4'd3), 32'h2);
        expect_reg(4'd3, 32'h1, "R3 add wraps");
        issue(mk(5'h04, 4'd3), 32'h1122_3344);
        expect_reg(4'd3, 32'h4433_2212, "R3 byte-reversed add");
    endtask

    task automatic t_xor_rot();
        issue(mk(5'h01, 4'd4), 32'h8000_0001);
        issue(mk(5'h07, 4'd4), 32'd33);
        expect_reg(4'd4, 32'h0000_0003, "R4 rotate mod 32");
        issue(mk(5'h07, 4'd4), 32'd0);
        expect_reg(4'd4, 32'h0000_0003, "R4 rotate zero");
        issue(mk(5'h06, 4'd4), 32'hF0F0_0F0F);
        expect_reg(4'd4, 32'hF0F0_0F0C, "R4 xor");
    endtask

    task automatic t_acc();
        issue(mk(5'h01, 4'd5), 32'd100);
        issue(mk(5'h08, 4'd5), 32'd0);
        expect_reg(4'd1, 32'd100, "R5 move to acc");
        issue(mk(5'h05, 4'd5), 32'd0);
        expect_reg(4'd1, 32'd200, "R5 add into acc");
        issue(mk(5'h09, 4'd6), 32'd0);
        expect_reg(4'd6, 32'd200, "R5 move from acc");
    endtask

    task automatic t_aes();
        issue(mk(5'h01, 4'd7), 32'h0001_0203);
        issue(mk(5'h0A, 4'd7), 32'd0);
        expect_reg(4'd7, 32'h637C_777B, "R6 sub bytes");
        issue(mk(5'h0B, 4'd7), 32'd0);
        expect_reg(4'd7, 32'h0001_0203, "R6 inv sub bytes");
        issue(mk(5'h01, 4'd7), 32'h53FF_1004);
        issue(mk(5'h0A, 4'd7), 32'd0);
        expect_reg(4'd7, 32'hED16_CAF2, "R6 sub bytes 2");
        issue(mk(5'h01, 4'd8), 32'hDB13_5345);
        issue(mk(5'h0C, 4'd8), 32'h0000_FFFF);
        expect_reg(4'd8, 32'h8E4D_5E43, "R7 mixcolumn xor");
        issue(mk(5'h01, 4'd8), 32'hF20A_225C);
        issue(mk(5'h0C, 4'd8), 32'd0);
        expect_reg(4'd8, 32'h9FDC_589D, "R7 mixcolumn");
    endtask

    task automatic t_packed();
        int bc;
        logic e;
        issue(mk(5'h01, 4'd2), 32'd5);
        issue(mk(5'h01, 4'd3), 32'd7);
        issue_packed(pack(3'b111, mk(5'h08, 4'd2), mk(5'h05, 4'd3), mk(5'h09, 4'd4)), bc, e);
        check(bc == 3, "R8 busy three cycles", bc, 3);
        expect_reg(4'd4, 32'd12, "R8 slot order A,B,C");
        issue_packed(pack(3'b110, mk(5'h08, 4'd3), mk(5'h09, 4'd6), mk(5'h09, 4'd9)), bc, e);
        check(bc == 2, "R8 busy two cycles", bc, 2);
        expect_reg(4'd6, 32'd7, "R8 two slots run");
        expect_reg(4'd9, 32'd0, "R8 unmarked slot ignored");
        // write while busy must be dropped
        @(negedge clk);
        cmd_valid = 1'b1; cmd_packed = 1'b1;
        cmd_word = pack(3'b111, 9'h000, 9'h000, 9'h000);
        @(negedge clk);
        cmd_packed = 1'b0; cmd_word = {23'b0, mk(5'h01, 4'd5)}; operand = 32'hDEAD;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        expect_reg(4'd5, 32'd100, "R8 write during busy ignored");
    endtask

    task automatic t_bad_marker();
        int bc;
        logic e;
        issue_packed(pack(3'b010, 9'h000, mk(5'h09, 4'd8), 9'h000), bc, e);
        check(e === 1'b1, "R9 err pulse", e, 1);
        check(bc == 0, "R9 no busy", bc, 0);
        @(negedge clk);
        check(err === 1'b0, "R9 err one cycle", err, 0);
        expect_reg(4'd8, 32'h9FDC_589D, "R9 nothing executed");
        expect_reg(4'd0, 32'd0, "R9 no flag");
    endtask

    task automatic t_illegal();
        int bc;
        logic e;
        issue(9'h1F0, 32'd0);
        expect_reg(4'd0, 32'd1, "R10 ill opcode flag");
        issue(mk(5'h09, 4'd1), 32'd0);
        expect_reg(4'd0, 32'd1, "R11 flag sticky");
        issue(mk(5'h01, 4'd0), 32'd0);
        expect_reg(4'd0, 32'd0, "R11 flag cleared");
        issue(mk(5'h0D, 4'd2), 32'd9);
        expect_reg(4'd0, 32'd1, "R10 reserved op flag");
        expect_reg(4'd2, 32'd5, "R10 reserved op no change");
        issue(mk(5'h01, 4'd0), 32'd0);
        issue(mk(5'h01, 4'd11), 32'd9);
        expect_reg(4'd0, 32'd1, "R10 bad selector flag");
        issue(mk(5'h01, 4'd0), 32'd0);
        issue(mk(5'h00, 4'd3), 32'd0);
        expect_reg(4'd0, 32'd1, "R10 nop with selector flag");
        issue(mk(5'h01, 4'd0), 32'd0);
        issue_packed(pack(3'b100, mk(5'h01, 4'd2), 9'h000, 9'h000), bc, e);
        expect_reg(4'd0, 32'd1, "R10 packed operand op flag");
        expect_reg(4'd2, 32'd5, "R10 packed operand op no change");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_store();
        t_add();
        t_xor_rot();
        t_acc();
        t_aes();
        t_packed();
        t_bad_marker();
        t_illegal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule